// File: doc/BRIEF.md
# Lane-Parallel Integer ALU with Shared Carry Mask

This block is the integer execution stage of a wide vector unit. Each accepted operation applies one two-operand opcode to every lane of a vector in the same cycle. Each lane receives two 32-bit operands, an enable bit and its bit of a lane-indexed carry mask. The carry mask has three roles. It is the carry or borrow input for the chained add and subtract forms. It is the destination of their carry or borrow output. It is also the condition bit of the lane select.

An issuing stage presents an opcode, the operand vectors, the enable vector and the current mask together with `in_valid`. One clock later the block returns the per-lane results and the updated mask, with `out_valid` high. The operand sources, the register writeback and any floating-point work belong to the neighbouring stages.

Top module: `simd_int_alu`

## Requirements
- R1: A request accepted with `in_valid` high at a clock edge produces its results on `out_result` and `out_mask`, with `out_valid` high, right after that edge. `out_valid` is low after an edge where `in_valid` was low, and both `out_result` and `out_mask` then hold their previous values.
- R2: `rst` high at a clock edge clears `out_valid`, every lane of `out_result` and every bit of `out_mask` to zero.
- R3: A lane whose `in_exec` bit is 0 keeps its previous `out_result` value, and its `out_mask` bit becomes its `in_mask` bit.
- R4: Addition opcodes work as follows (A = lane slice of `in_src_a`, B = lane slice of `in_src_b`, results modulo 2^32):
  - 0x00 returns A+B.
  - 0x01 returns A+B and sets the mask bit when the 33-bit zero-extended sum is at least 2^32.
  - 0x02 adds the lane's mask bit as well and replaces that bit with the new carry, using the same threshold.
- R5: Subtraction opcodes work as follows:
  - 0x03 returns A-B.
  - 0x04 returns B-A.
  - 0x05 returns A-B and sets the mask bit when B > A.
  - 0x06 returns B-A and sets the mask bit when A > B.
- R6: Subtraction with borrow-in also subtracts the lane's mask bit c:
  - 0x07 returns A-B-c, with the new bit set when B+c > A.
  - 0x08 returns B-A-c, with the new bit set when A+c > B.
- R7: 32-bit shifts take the value from B and the amount from A[4:0] only. 0x09 shifts left logically, 0x0A shifts right logically and 0x0B shifts right arithmetically.
- R8: 16-bit shifts take B[15:0] as the value and A[3:0] as the amount. 0x0C shifts left, 0x0D shifts right logically and 0x0E shifts right arithmetically. Result bits 31:16 are zero.
- R9: Bitwise opcodes are 0x0F AND, 0x10 OR, 0x11 XOR and 0x12 XNOR, where XNOR is the inverse of A XOR B.
- R10: Minimum and maximum opcodes are 0x13 unsigned min, 0x14 unsigned max, 0x15 signed min and 0x16 signed max.
- R11: Multiply opcodes multiply A[23:0] by B[23:0]:
  - 0x17 returns product bits 31:0, unsigned.
  - 0x18 returns product bits 63:32, unsigned.
  - 0x19 returns product bits 31:0 with both operands sign-extended from bit 23.
  - 0x1A returns product bits 63:32 with both operands sign-extended from bit 23.
- R12: Opcode 0x1B returns B when the lane's `in_mask` bit is 1 and A when it is 0.
- R13: Only opcodes 0x01, 0x02 and 0x05 through 0x08 can change a mask bit. For every other opcode, `out_mask` equals `in_mask`. Opcodes 0x1C to 0x1F give zero in enabled lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 5 | Opcode applied to all lanes |
| in_exec | input | LANES | Per-lane enable |
| in_mask | input | LANES | Current carry/condition mask |
| in_src_a | input | 32*LANES | First operand, lane i at bits 32i+31:32i |
| in_src_b | input | 32*LANES | Second operand, same packing |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 32*LANES | Registered per-lane results |
| out_mask | output | LANES | Registered updated mask |

## Verification
The embedded properties cover four rules on every cycle:
- the one-cycle valid relation and the hold of results and mask while idle;
- the freeze of disabled lanes;
- the pass-through of the mask for opcodes that produce no carry;
- the select's choice between the operands.

Arithmetic values are left to the bench. Its behavioural model covers the 2^32 carry threshold, equal-operand borrows, masked shift amounts, the signed high half of the 24-bit products and a reset issued in the middle of traffic. It does this by comparing every lane against its own computation on every clock, across corner operands and random enable and mask patterns.

// File: rtl/simd_alu_pkg.sv
package simd_alu_pkg;
  localparam int DW  = 32;
  localparam int MW  = 24;
  localparam int OPW = 5;
  localparam int PW  = 2 * DW;

  typedef enum logic [OPW-1:0] {
    OP_ADD       = 5'h00,
    OP_ADD_CO    = 5'h01,
    OP_ADD_CI    = 5'h02,
    OP_SUB       = 5'h03,
    OP_RSUB      = 5'h04,
    OP_SUB_BO    = 5'h05,
    OP_RSUB_BO   = 5'h06,
    OP_SUB_BI    = 5'h07,
    OP_RSUB_BI   = 5'h08,
    OP_SHL32     = 5'h09,
    OP_SHR32     = 5'h0A,
    OP_SRA32     = 5'h0B,
    OP_SHL16     = 5'h0C,
    OP_SHR16     = 5'h0D,
    OP_SRA16     = 5'h0E,
    OP_AND       = 5'h0F,
    OP_OR        = 5'h10,
    OP_XOR       = 5'h11,
    OP_XNOR      = 5'h12,
    OP_UMIN      = 5'h13,
    OP_UMAX      = 5'h14,
    OP_SMIN      = 5'h15,
    OP_SMAX      = 5'h16,
    OP_UMUL_LO   = 5'h17,
    OP_UMUL_HI   = 5'h18,
    OP_SMUL_LO   = 5'h19,
    OP_SMUL_HI   = 5'h1A,
    OP_PICK      = 5'h1B
  } alu_op_e;

  function automatic logic op_writes_carry(logic [OPW-1:0] op);
    case (op)
      OP_ADD_CO, OP_ADD_CI, OP_SUB_BO, OP_RSUB_BO, OP_SUB_BI, OP_RSUB_BI:
        op_writes_carry = 1'b1;
      default:
        op_writes_carry = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/simd_mul24.sv
module simd_mul24
  import simd_alu_pkg::*;
(
  input  logic          is_signed,
  input  logic [MW-1:0] op_a,
  input  logic [MW-1:0] op_b,
  output logic [PW-1:0] product
);
  localparam int XW = MW + 1;
  localparam int FW = 2 * XW;

  logic signed [XW-1:0] ext_a;
  logic signed [XW-1:0] ext_b;
  logic signed [FW-1:0] full;

  always_comb begin
    ext_a   = $signed({is_signed & op_a[MW-1], op_a});
    ext_b   = $signed({is_signed & op_b[MW-1], op_b});
    full    = ext_a * ext_b;
    product = {{(PW-FW){full[FW-1]}}, full};
  end
endmodule

// File: rtl/simd_lane_alu.sv
module simd_lane_alu
  import simd_alu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  src_a,
  input  logic [DW-1:0]  src_b,
  input  logic           mask_in,
  output logic [DW-1:0]  result,
  output logic           carry
);
  localparam int SHW  = $clog2(DW);
  localparam int HW   = DW / 2;
  localparam int SHWH = $clog2(HW);

  logic [PW-1:0]  prod;
  logic           mul_signed;
  logic [DW:0]    wide;
  logic [DW:0]    cmp_l;
  logic [DW:0]    cmp_r;
  logic [HW-1:0]  half;
  logic [DW-1:0]  cin_w;

  assign mul_signed = (op == OP_SMUL_LO) || (op == OP_SMUL_HI);
  assign cin_w      = {{(DW-1){1'b0}}, mask_in};

  simd_mul24 u_mul (
    .is_signed (mul_signed),
    .op_a      (src_a[MW-1:0]),
    .op_b      (src_b[MW-1:0]),
    .product   (prod)
  );

  always_comb begin
    result = '0;
    carry  = 1'b0;
    wide   = '0;
    cmp_l  = '0;
    cmp_r  = '0;
    half   = '0;
    case (op)
      OP_ADD: result = src_a + src_b;
      OP_ADD_CO, OP_ADD_CI: begin
        wide   = {1'b0, src_a} + {1'b0, src_b} + ((op == OP_ADD_CI) ? {1'b0, cin_w} : '0);
        result = wide[DW-1:0];
        carry  = wide[DW];
      end
      OP_SUB:  result = src_a - src_b;
      OP_RSUB: result = src_b - src_a;
      OP_SUB_BO, OP_SUB_BI: begin
        cmp_l  = {1'b0, src_b} + ((op == OP_SUB_BI) ? {1'b0, cin_w} : '0);
        cmp_r  = {1'b0, src_a};
        result = src_a - cmp_l[DW-1:0];
        carry  = cmp_l > cmp_r;
      end
      OP_RSUB_BO, OP_RSUB_BI: begin
        cmp_l  = {1'b0, src_a} + ((op == OP_RSUB_BI) ? {1'b0, cin_w} : '0);
        cmp_r  = {1'b0, src_b};
        result = src_b - cmp_l[DW-1:0];
        carry  = cmp_l > cmp_r;
      end
      OP_SHL32: result = src_b << src_a[SHW-1:0];
      OP_SHR32: result = src_b >> src_a[SHW-1:0];
      OP_SRA32: result = $signed(src_b) >>> src_a[SHW-1:0];
      OP_SHL16: begin
        half   = src_b[HW-1:0] << src_a[SHWH-1:0];
        result = {{HW{1'b0}}, half};
      end
      OP_SHR16: begin
        half   = src_b[HW-1:0] >> src_a[SHWH-1:0];
        result = {{HW{1'b0}}, half};
      end
      OP_SRA16: begin
        half   = $signed(src_b[HW-1:0]) >>> src_a[SHWH-1:0];
        result = {{HW{1'b0}}, half};
      end
      OP_AND:  result = src_a & src_b;
      OP_OR:   result = src_a | src_b;
      OP_XOR:  result = src_a ^ src_b;
      OP_XNOR: result = ~(src_a ^ src_b);
      OP_UMIN: result = (src_a < src_b) ? src_a : src_b;
      OP_UMAX: result = (src_a > src_b) ? src_a : src_b;
      OP_SMIN: result = ($signed(src_a) < $signed(src_b)) ? src_a : src_b;
      OP_SMAX: result = ($signed(src_a) > $signed(src_b)) ? src_a : src_b;
      OP_UMUL_LO, OP_SMUL_LO: result = prod[DW-1:0];
      OP_UMUL_HI, OP_SMUL_HI: result = prod[PW-1:DW];
      OP_PICK: result = mask_in ? src_b : src_a;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/simd_int_alu.sv
module simd_int_alu
  import simd_alu_pkg::*;
#(
  parameter int LANES = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic [OPW-1:0]      in_op,
  input  logic [LANES-1:0]    in_exec,
  input  logic [LANES-1:0]    in_mask,
  input  logic [LANES*DW-1:0] in_src_a,
  input  logic [LANES*DW-1:0] in_src_b,
  output logic                out_valid,
  output logic [LANES*DW-1:0] out_result,
  output logic [LANES-1:0]    out_mask
);
  logic                carry_op;
  logic [LANES*DW-1:0] res_q;
  logic [LANES-1:0]    mask_q;
  logic                valid_q;

  assign carry_op   = op_writes_carry(in_op);
  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_mask   = mask_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= in_valid;
  end

  assert_valid_follow_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [DW-1:0] lane_res;
    logic          lane_carry;
    logic          lane_mask_nxt;

    simd_lane_alu u_alu (
      .op      (in_op),
      .src_a   (in_src_a[i*DW +: DW]),
      .src_b   (in_src_b[i*DW +: DW]),
      .mask_in (in_mask[i]),
      .result  (lane_res),
      .carry   (lane_carry)
    );

    assign lane_mask_nxt = (in_exec[i] && carry_op) ? lane_carry : in_mask[i];

    always_ff @(posedge clk) begin
      if (rst) begin
        res_q[i*DW +: DW] <= '0;
        mask_q[i]         <= 1'b0;
      end else if (in_valid) begin
        if (in_exec[i]) res_q[i*DW +: DW] <= lane_res;
        mask_q[i] <= lane_mask_nxt;
      end
    end

    assert_hold_idle_R1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> ($stable(out_result[i*DW +: DW]) && $stable(out_mask[i])));
    assert_exec_off_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_exec[i]) |=>
        ($stable(out_result[i*DW +: DW]) && (out_mask[i] == $past(in_mask[i]))));
    assert_mask_keep_R13: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !op_writes_carry(in_op)) |=> (out_mask[i] == $past(in_mask[i])));
    assert_pick_R12: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_exec[i] && (in_op == OP_PICK)) |=>
        (out_result[i*DW +: DW] ==
         ($past(in_mask[i]) ? $past(in_src_b[i*DW +: DW]) : $past(in_src_a[i*DW +: DW]))));
  end
endmodule

// File: tb/simd_int_alu_bench.sv
module simd_int_alu_bench;
  localparam int L = 8;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [4:0]      in_op = '0;
  logic [L-1:0]    in_exec = '0;
  logic [L-1:0]    in_mask = '0;
  logic [L*32-1:0] in_src_a = '0;
  logic [L*32-1:0] in_src_b = '0;
  logic            out_valid;
  logic [L*32-1:0] out_result;
  logic [L-1:0]    out_mask;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  logic [31:0] exp_res [L];
  logic [L-1:0] exp_mask = '0;
  logic         exp_valid = 1'b0;
  logic [4:0]   last_op = '0;
  logic [L-1:0] last_exec = '0;
  logic         last_valid = 1'b0;
  logic         last_rst = 1'b1;

  simd_int_alu #(.LANES(L)) u_simd_int_alu (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_exec(in_exec), .in_mask(in_mask), .in_src_a(in_src_a),
    .in_src_b(in_src_b), .out_valid(out_valid), .out_result(out_result),
    .out_mask(out_mask)
  );

  always #5 clk = ~clk;

  function automatic string tag_of(logic [4:0] op);
    if (op <= 5'h02) return "R4";
    if (op <= 5'h06) return "R5";
    if (op <= 5'h08) return "R6";
    if (op <= 5'h0B) return "R7";
    if (op <= 5'h0E) return "R8";
    if (op <= 5'h12) return "R9";
    if (op <= 5'h16) return "R10";
    if (op <= 5'h1A) return "R11";
    if (op == 5'h1B) return "R12";
    return "R13";
  endfunction

  function automatic bit is_carry(logic [4:0] op);
    return (op == 5'h01) || (op == 5'h02) || (op >= 5'h05 && op <= 5'h08);
  endfunction

  task automatic ref_lane(input logic [4:0] op, input logic [31:0] a, input logic [31:0] b,
                          input logic c, output logic [31:0] r, output logic co);
    longint unsigned ua, ub, uc, p;
    longint sp;
    int sa, sb;
    logic [15:0] h;
    shortint sh;
    ua = 64'(a); ub = 64'(b); uc = 64'(c);
    co = c; r = '0;
    case (op)
      5'h00: r = a + b;
      5'h01: begin r = a + b; co = (ua + ub) >= 64'h1_0000_0000; end
      5'h02: begin r = 32'(ua + ub + uc); co = (ua + ub + uc) >= 64'h1_0000_0000; end
      5'h03: r = a - b;
      5'h04: r = b - a;
      5'h05: begin r = a - b; co = ub > ua; end
      5'h06: begin r = b - a; co = ua > ub; end
      5'h07: begin r = 32'(ua - ub - uc); co = (ub + uc) > ua; end
      5'h08: begin r = 32'(ub - ua - uc); co = (ua + uc) > ub; end
      5'h09: r = b << a[4:0];
      5'h0A: r = b >> a[4:0];
      5'h0B: r = 32'($signed(b) >>> a[4:0]);
      5'h0C: begin h = b[15:0] << a[3:0]; r = {16'h0, h}; end
      5'h0D: begin h = b[15:0] >> a[3:0]; r = {16'h0, h}; end
      5'h0E: begin sh = shortint'(b[15:0]); sh = sh >>> a[3:0]; r = {16'h0, 16'(sh)}; end
      5'h0F: r = a & b;
      5'h10: r = a | b;
      5'h11: r = a ^ b;
      5'h12: r = ~(a ^ b);
      5'h13: r = (a < b) ? a : b;
      5'h14: r = (a > b) ? a : b;
      5'h15: r = (int'(a) < int'(b)) ? a : b;
      5'h16: r = (int'(a) > int'(b)) ? a : b;
      5'h17: begin p = 64'(a[23:0]) * 64'(b[23:0]); r = p[31:0]; end
      5'h18: begin p = 64'(a[23:0]) * 64'(b[23:0]); r = p[63:32]; end
      5'h19, 5'h1A: begin
        sa = int'({{8{a[23]}}, a[23:0]});
        sb = int'({{8{b[23]}}, b[23:0]});
        sp = longint'(sa) * longint'(sb);
        r = (op == 5'h19) ? sp[31:0] : sp[63:32];
      end
      5'h1B: r = c ? b : a;
      default: r = '0;
    endcase
  endtask

  always @(posedge clk) begin
    logic [31:0] r;
    logic co;
    last_rst = rst;
    last_valid = in_valid;
    last_op = in_op;
    last_exec = in_exec;
    if (rst) begin
      exp_valid = 1'b0;
      exp_mask = '0;
      for (int i = 0; i < L; i++) exp_res[i] = '0;
    end else begin
      exp_valid = in_valid;
      if (in_valid) begin
        for (int i = 0; i < L; i++) begin
          ref_lane(in_op, in_src_a[i*32 +: 32], in_src_b[i*32 +: 32], in_mask[i], r, co);
          if (in_exec[i]) exp_res[i] = r;
          exp_mask[i] = (in_exec[i] && is_carry(in_op)) ? co : in_mask[i];
        end
      end
    end
  end

  task automatic check_all();
    string t;
    compared++;
    if (out_valid !== exp_valid) begin
      mismatched++;
      $display("FAIL %s valid: got %0b expected %0b", last_rst ? "R2" : "R1", out_valid, exp_valid);
    end
    for (int i = 0; i < L; i++) begin
      if (last_rst) t = "R2";
      else if (!last_valid) t = "R1";
      else if (!last_exec[i]) t = "R3";
      else t = tag_of(last_op);
      compared++;
      if (out_result[i*32 +: 32] !== exp_res[i]) begin
        mismatched++;
        $display("FAIL %s lane %0d op %h result: got %h expected %h",
                 t, i, last_op, out_result[i*32 +: 32], exp_res[i]);
      end
      if (!last_rst && last_valid && last_exec[i])
        t = is_carry(last_op) ? tag_of(last_op) : "R13";
      compared++;
      if (out_mask[i] !== exp_mask[i]) begin
        mismatched++;
        $display("FAIL %s lane %0d op %h mask: got %0b expected %0b",
                 t, i, last_op, out_mask[i], exp_mask[i]);
      end
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 11))
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h8000_0000;
      4: return 32'h7FFF_FFFF;
      5: return 32'h00FF_FFFF;
      6: return 32'h0080_0000;
      7: return 32'h0000_001F;
      8: return 32'hFFFF_8000;
      9: return 32'h0000_0010;
      default: return $urandom();
    endcase
  endfunction

  task automatic step();
    @(negedge clk);
    check_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < L; i++) exp_res[i] = '0;
    repeat (3) @(posedge clk);
    step(); // R2: reset state
    rst = 1'b0;
    for (int op = 0; op < 32; op++) begin
      for (int rep = 0; rep < 30; rep++) begin
        in_valid = (rep % 7 != 3);
        in_op = 5'(op);
        in_exec = (rep < 10) ? '1 : L'($urandom());
        in_mask = L'($urandom());
        for (int i = 0; i < L; i++) begin
          logic [31:0] va, vb;
          va = pick_val();
          vb = (rep % 5 == 0) ? va : pick_val();
          if (rep == 1) begin va = 32'hFFFF_FFFF; vb = 32'h0000_0001 - 32'(i % 2); end
          in_src_a[i*32 +: 32] = va;
          in_src_b[i*32 +: 32] = vb;
        end
        step();
      end
      if (op == 16) begin
        rst = 1'b1;  // R2: reset in the middle of traffic
        step();
        rst = 1'b0;
      end
    end
    in_valid = 1'b0;
    step();
    step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule